// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator

This block sits beside the storage of a dual-clock FIFO and drives its two programmable threshold flags. Both are active low. The almost-full flag warns the writer when the free space has dropped to the programmed full offset. The almost-empty flag warns the reader when the stored word count has fallen to the programmed empty offset. The block receives the binary write pointer in the write clock domain and the binary read pointer in the read clock domain. It also receives a marked read position that replaces the read pointer in the almost-full comparison while retransmission is enabled. Each pointer is converted to Gray code, carried into the other domain through a two-stage synchronizer, and converted back to binary. This gives every domain its own word count for each flag.

Two pointer bits beyond the address width are not used. One wrap bit is enough: pointers are one bit wider than the address, and all counts are taken modulo twice the depth. A mode input selects the standard read mode or the first-word-fall-through (FWFT) mode. FWFT raises both thresholds by one word, because the word held in the output register also counts. A configuration input selects how the flags are clocked. In the single-clock form, each flag is a register in its own domain. In the two-clock form, the owning clock drives a flag low and the opposite clock releases it.

The two offsets are registers. Each resets to a quarter of the depth and is reloaded through a load strobe in its own domain. They are meant to change only while both ports are idle.

Top module: `afe_prog_flags`

## Requirements
- R1: While reset is asserted, both flags read high. After reset, both offsets equal DEPTH/4 until they are loaded.
- R2: In standard mode (fwft_mode=0), paf_n settles low exactly when the write-side count (wr_ptr minus the reference pointer, modulo 2*DEPTH) is at least DEPTH minus the full offset.
- R3: In FWFT mode (fwft_mode=1), paf_n settles low exactly when that count is at least DEPTH+1 minus the full offset.
- R4: In standard mode, pae_n settles low exactly when the count wr_ptr minus rd_ptr is at most the empty offset.
- R5: In FWFT mode, pae_n settles low exactly when that count is at most the empty offset plus one.
- R6: With async_cfg=0, paf_n changes only on wclk and pae_n changes only on rclk. Stopping the owning clock freezes the flag, even when the other pointer moves.
- R7: With async_cfg=1, paf_n is driven low on wclk and released high on rclk, and pae_n is driven low on rclk and released high on wclk. Each flag can be released while its owning clock is stopped.
- R8: With retx_en=1, the almost-full count uses mark_ptr in place of rd_ptr. The almost-empty count still uses rd_ptr.
- R9: full_ofs_in is captured on a wclk edge only when full_ofs_ld=1, and empty_ofs_in on an rclk edge only when empty_ofs_ld=1. Otherwise the offset holds and changes on the inputs have no effect on the flags.
- R10: Counts wrap correctly when a pointer has passed through zero. The pointers are DEPTH-modulo addresses plus one wrap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write domain clock |
| wrst_n | input | 1 | Write domain asynchronous reset, active low |
| rclk | input | 1 | Read domain clock |
| rrst_n | input | 1 | Read domain asynchronous reset, active low |
| wr_ptr | input | PW | Binary write pointer (write domain), address plus wrap bit |
| rd_ptr | input | PW | Binary read pointer (read domain) |
| mark_ptr | input | PW | Marked read position used for retransmission (read domain) |
| retx_en | input | 1 | 1: almost-full is measured against mark_ptr |
| fwft_mode | input | 1 | 0: standard mode, 1: FWFT mode |
| async_cfg | input | 1 | 0: single-clock flags, 1: set/release by opposite clocks |
| full_ofs_ld | input | 1 | Load strobe for the full offset (wclk) |
| full_ofs_in | input | AW | New full offset value |
| empty_ofs_ld | input | 1 | Load strobe for the empty offset (rclk) |
| empty_ofs_in | input | AW | New empty offset value |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
The hardest situation to reach is a flag released by the clock that does not own it, with the owning clock silent. With both clocks running, the single-clock and two-clock forms settle to the same value, so nothing at the ports tells them apart. The bench therefore gates one clock off and then moves the pointer in the domain that is still running. A released flag proves the two-clock path. A frozen flag in the single-clock configuration proves that this flag has only one clock.

// File: rtl/afe_pkg.sv
package afe_pkg;
  typedef enum logic {
    CFG_SYNC  = 1'b0,
    CFG_ASYNC = 1'b1
  } flag_cfg_e;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } read_mode_e;
endpackage

// File: rtl/afe_ofs_reg.sv
module afe_ofs_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (ld) q <= din;
  end

  // R9: without a load strobe the offset never moves
  a_r9_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld) |-> $stable(q));
endmodule

// File: rtl/afe_ptr_sync.sv
module afe_ptr_sync #(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [PW-1:0] dst_bin
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] src_gray_q;
  logic [PW-1:0] chain_q [STAGES];

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_gray_q <= '0;
    else src_gray_q <= to_gray(src_bin);
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) chain_q[0] <= '0;
        else chain_q[0] <= src_gray_q;
      end
    end else begin : g_next
      always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) chain_q[s] <= '0;
        else chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign dst_bin = from_gray(chain_q[STAGES-1]);
endmodule

// File: rtl/afe_flag_cell.sv
module afe_flag_cell (
  input  logic set_clk,
  input  logic set_rst_n,
  input  logic clr_clk,
  input  logic clr_rst_n,
  input  logic cfg_async,
  input  logic hit_set,
  input  logic hit_clr,
  output logic flag_n
);
  logic sync_n_q;
  logic set_tgl_q;
  logic clr_tgl_q;
  logic async_low;
  logic set_evt;
  logic clr_evt;

  assign async_low = set_tgl_q ^ clr_tgl_q;
  assign set_evt   = cfg_async && hit_set && !async_low;
  assign clr_evt   = cfg_async && !hit_clr && async_low;

  always_ff @(posedge set_clk or negedge set_rst_n) begin
    if (!set_rst_n) begin
      sync_n_q  <= 1'b1;
      set_tgl_q <= 1'b0;
    end else begin
      sync_n_q <= !hit_set;
      if (set_evt) set_tgl_q <= !set_tgl_q;
    end
  end

  always_ff @(posedge clr_clk or negedge clr_rst_n) begin
    if (!clr_rst_n) clr_tgl_q <= 1'b0;
    else if (clr_evt) clr_tgl_q <= !clr_tgl_q;
  end

  assign flag_n = cfg_async ? !async_low : sync_n_q;

  // R6: single-clock form tracks the owning domain's hit one edge later
  a_r6_sync_follow: assert property (@(posedge set_clk) disable iff (!set_rst_n)
    !cfg_async |=> (cfg_async || flag_n == !$past(hit_set)));

  // R7: the owning clock only ever drives the flag low
  a_r7_set_only_on_hit: assert property (@(posedge set_clk) disable iff (!set_rst_n || !clr_rst_n)
    (set_tgl_q != $past(set_tgl_q)) |-> ($past(hit_set) && $past(cfg_async)));

  // R7: the opposite clock only ever releases the flag
  a_r7_clr_only_on_miss: assert property (@(posedge clr_clk) disable iff (!set_rst_n || !clr_rst_n)
    (clr_tgl_q != $past(clr_tgl_q)) |-> (!$past(hit_clr) && $past(cfg_async)));
endmodule

// File: rtl/afe_prog_flags.sv
module afe_prog_flags
  import afe_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  input  logic [PW-1:0] mark_ptr,
  input  logic          retx_en,
  input  logic          fwft_mode,
  input  logic          async_cfg,
  input  logic          full_ofs_ld,
  input  logic [AW-1:0] full_ofs_in,
  input  logic          empty_ofs_ld,
  input  logic [AW-1:0] empty_ofs_in,
  output logic          paf_n,
  output logic          pae_n
);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] OFS_DEF = AW'(DEPTH / 4);
  localparam int N_R2W = 2;

  // threshold arithmetic, one word higher in FWFT mode
  function automatic logic af_hit(input logic [PW-1:0] cnt, input logic [AW-1:0] m,
                                  input logic fwft);
    logic [CW-1:0] lhs;
    logic [CW-1:0] rhs;
    lhs = {1'b0, cnt} + {2'b00, m};
    rhs = CW'(DEPTH) + {{(CW-1){1'b0}}, fwft};
    return lhs >= rhs;
  endfunction

  function automatic logic ae_hit(input logic [PW-1:0] cnt, input logic [AW-1:0] n,
                                  input logic fwft);
    logic [CW-1:0] lim;
    lim = {2'b00, n} + {{(CW-1){1'b0}}, fwft};
    return {1'b0, cnt} <= lim;
  endfunction

  read_mode_e mode;
  flag_cfg_e  cfg;
  logic       fwft;
  logic       use_async;

  assign mode      = read_mode_e'(fwft_mode);
  assign cfg       = flag_cfg_e'(async_cfg);
  assign fwft      = (mode == MODE_FWFT);
  assign use_async = (cfg == CFG_ASYNC);

  // offsets
  logic [AW-1:0] full_ofs_q;
  logic [AW-1:0] empty_ofs_q;

  afe_ofs_reg #(.W(AW), .RST_VAL(OFS_DEF)) u_full_ofs (
    .clk(wclk), .rst_n(wrst_n), .ld(full_ofs_ld), .din(full_ofs_in), .q(full_ofs_q));

  afe_ofs_reg #(.W(AW), .RST_VAL(OFS_DEF)) u_empty_ofs (
    .clk(rclk), .rst_n(rrst_n), .ld(empty_ofs_ld), .din(empty_ofs_in), .q(empty_ofs_q));

  // read-domain pointers into the write domain: index 0 read, 1 mark
  logic [PW-1:0] r2w_src [N_R2W];
  logic [PW-1:0] r2w_dst [N_R2W];

  assign r2w_src[0] = rd_ptr;
  assign r2w_src[1] = mark_ptr;

  for (genvar gi = 0; gi < N_R2W; gi++) begin : g_r2w
    afe_ptr_sync #(.PW(PW), .STAGES(2)) u_sync (
      .src_clk(rclk), .src_rst_n(rrst_n), .src_bin(r2w_src[gi]),
      .dst_clk(wclk), .dst_rst_n(wrst_n), .dst_bin(r2w_dst[gi]));
  end

  logic [PW-1:0] wr_in_r;

  afe_ptr_sync #(.PW(PW), .STAGES(2)) u_w2r (
    .src_clk(wclk), .src_rst_n(wrst_n), .src_bin(wr_ptr),
    .dst_clk(rclk), .dst_rst_n(rrst_n), .dst_bin(wr_in_r));

  // per-domain fill counts
  logic [PW-1:0] af_ref_w;
  logic [PW-1:0] af_ref_r;
  logic [PW-1:0] w_fill_af;
  logic [PW-1:0] w_fill_ae;
  logic [PW-1:0] r_fill_af;
  logic [PW-1:0] r_fill_ae;

  assign af_ref_w  = retx_en ? r2w_dst[1] : r2w_dst[0];
  assign af_ref_r  = retx_en ? mark_ptr : rd_ptr;
  assign w_fill_af = wr_ptr - af_ref_w;
  assign w_fill_ae = wr_ptr - r2w_dst[0];
  assign r_fill_af = wr_in_r - af_ref_r;
  assign r_fill_ae = wr_in_r - rd_ptr;

  logic af_hit_w;
  logic af_hit_r;
  logic ae_hit_w;
  logic ae_hit_r;

  assign af_hit_w = af_hit(w_fill_af, full_ofs_q, fwft);
  assign af_hit_r = af_hit(r_fill_af, full_ofs_q, fwft);
  assign ae_hit_r = ae_hit(r_fill_ae, empty_ofs_q, fwft);
  assign ae_hit_w = ae_hit(w_fill_ae, empty_ofs_q, fwft);

  // almost-full: owned by wclk, released by rclk in the two-clock form
  afe_flag_cell u_af_cell (
    .set_clk(wclk), .set_rst_n(wrst_n), .clr_clk(rclk), .clr_rst_n(rrst_n),
    .cfg_async(use_async), .hit_set(af_hit_w), .hit_clr(af_hit_r), .flag_n(paf_n));

  // almost-empty: owned by rclk, released by wclk in the two-clock form
  afe_flag_cell u_ae_cell (
    .set_clk(rclk), .set_rst_n(rrst_n), .clr_clk(wclk), .clr_rst_n(wrst_n),
    .cfg_async(use_async), .hit_set(ae_hit_r), .hit_clr(ae_hit_w), .flag_n(pae_n));
endmodule

// File: tb/afe_prog_flags_bench.sv
module afe_prog_flags_bench;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int PW = 5;

  typedef struct packed {
    logic          fwft;
    logic          asy;
    logic          retx;
    logic [PW-1:0] wr;
    logic [PW-1:0] rd;
    logic [PW-1:0] mark;
    logic [AW-1:0] m;
    logic [AW-1:0] n;
    logic          exp_paf;
    logic          exp_pae;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,5'd12,5'd0, 5'd0,4'd4,4'd4,1'b0,1'b1}, // R2 at threshold
    '{1'b0,1'b0,1'b0,5'd11,5'd0, 5'd0,4'd4,4'd4,1'b1,1'b1}, // R2 one below
    '{1'b1,1'b0,1'b0,5'd12,5'd0, 5'd0,4'd4,4'd4,1'b1,1'b1}, // R3 one below
    '{1'b1,1'b0,1'b0,5'd13,5'd0, 5'd0,4'd4,4'd4,1'b0,1'b1}, // R3 at threshold
    '{1'b0,1'b0,1'b0,5'd4, 5'd0, 5'd0,4'd4,4'd4,1'b1,1'b0}, // R4 at n
    '{1'b0,1'b0,1'b0,5'd5, 5'd0, 5'd0,4'd4,4'd4,1'b1,1'b1}, // R4 n+1
    '{1'b1,1'b0,1'b0,5'd5, 5'd0, 5'd0,4'd4,4'd4,1'b1,1'b0}, // R5 at n+1
    '{1'b1,1'b0,1'b0,5'd6, 5'd0, 5'd0,4'd4,4'd4,1'b1,1'b1}, // R5 n+2
    '{1'b0,1'b1,1'b0,5'd14,5'd2, 5'd0,4'd4,4'd4,1'b0,1'b1}, // R7 R2 two-clock
    '{1'b0,1'b1,1'b0,5'd3, 5'd23,5'd0,4'd4,4'd4,1'b0,1'b1}, // R10 wrapped pointers
    '{1'b0,1'b0,1'b1,5'd12,5'd10,5'd0,4'd4,4'd4,1'b0,1'b0}, // R8 mark used
    '{1'b0,1'b0,1'b0,5'd12,5'd10,5'd0,4'd4,4'd4,1'b1,1'b0}, // R8 mark ignored
    '{1'b0,1'b0,1'b0,5'd14,5'd0, 5'd0,4'd2,4'd1,1'b0,1'b1}, // R9 R2 new m
    '{1'b0,1'b0,1'b0,5'd1, 5'd0, 5'd0,4'd2,4'd1,1'b1,1'b0}, // R9 R4 new n
    '{1'b0,1'b0,1'b0,5'd16,5'd0, 5'd0,4'd0,4'd0,1'b0,1'b1}, // R2 full, m=0
    '{1'b0,1'b0,1'b0,5'd0, 5'd0, 5'd0,4'd0,4'd0,1'b1,1'b0}, // R4 empty, n=0
    '{1'b1,1'b0,1'b0,5'd0, 5'd0, 5'd0,4'd0,4'd0,1'b1,1'b0}, // R5 empty, n=0
    '{1'b1,1'b1,1'b0,5'd7, 5'd2, 5'd0,4'd4,4'd4,1'b1,1'b0}, // R7 R5 two-clock
    '{1'b0,1'b1,1'b1,5'd12,5'd10,5'd0,4'd4,4'd4,1'b0,1'b0}, // R8 two-clock
    '{1'b1,1'b1,1'b0,5'd1, 5'd31,5'd0,4'd4,4'd4,1'b1,1'b0}  // R10 R5 wrap
  };

  logic clk = 1'b0;
  logic wen = 1'b1;
  logic ren = 1'b1;
  logic rst_n = 1'b0;
  logic wclk;
  logic rclk;
  logic [PW-1:0] wr_ptr = '0;
  logic [PW-1:0] rd_ptr = '0;
  logic [PW-1:0] mark_ptr = '0;
  logic retx_en = 1'b0;
  logic fwft_mode = 1'b0;
  logic async_cfg = 1'b0;
  logic full_ofs_ld = 1'b0;
  logic [AW-1:0] full_ofs_in = '0;
  logic empty_ofs_ld = 1'b0;
  logic [AW-1:0] empty_ofs_in = '0;
  logic paf_n;
  logic pae_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign wclk = clk & wen;
  assign rclk = clk & ren;

  afe_prog_flags #(.DEPTH(DEPTH)) u_afe_prog_flags (
    .wclk(wclk), .wrst_n(rst_n), .rclk(rclk), .rrst_n(rst_n),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .mark_ptr(mark_ptr),
    .retx_en(retx_en), .fwft_mode(fwft_mode), .async_cfg(async_cfg),
    .full_ofs_ld(full_ofs_ld), .full_ofs_in(full_ofs_in),
    .empty_ofs_ld(empty_ofs_ld), .empty_ofs_in(empty_ofs_in),
    .paf_n(paf_n), .pae_n(pae_n));

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic load_ofs(input logic [AW-1:0] m, input logic [AW-1:0] n);
    @(negedge clk);
    full_ofs_in = m; empty_ofs_in = n; full_ofs_ld = 1'b1; empty_ofs_ld = 1'b1;
    @(negedge clk);
    full_ofs_ld = 1'b0; empty_ofs_ld = 1'b0;
  endtask

  task automatic set_ptrs(input logic [PW-1:0] w, input logic [PW-1:0] r);
    @(negedge clk);
    wr_ptr = w; rd_ptr = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    settle(3);
    check("R1 reset paf_n", paf_n, 1'b1);
    check("R1 reset pae_n", pae_n, 1'b1);
    rst_n = 1'b1;

    // R1 defaults: offsets DEPTH/4 = 4
    set_ptrs(5'd12, 5'd0);
    settle(10);
    check("R1 default full offset", paf_n, 1'b0);
    set_ptrs(5'd4, 5'd0);
    settle(10);
    check("R1 default empty offset", pae_n, 1'b0);

    // R9: offset inputs without strobe are ignored
    @(negedge clk);
    empty_ofs_in = 4'd9; full_ofs_in = 4'd9;
    set_ptrs(5'd5, 5'd0);
    settle(10);
    check("R9 unloaded empty offset", pae_n, 1'b1);
    set_ptrs(5'd11, 5'd0);
    settle(10);
    check("R9 unloaded full offset", paf_n, 1'b1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      load_ofs(VECS[i].m, VECS[i].n);
      @(negedge clk);
      fwft_mode = VECS[i].fwft; async_cfg = VECS[i].asy; retx_en = VECS[i].retx;
      mark_ptr = VECS[i].mark;
      set_ptrs(VECS[i].wr, VECS[i].rd);
      settle(10);
      check($sformatf("vector %0d paf_n", i), paf_n, VECS[i].exp_paf);
      check($sformatf("vector %0d pae_n", i), pae_n, VECS[i].exp_pae);
    end

    // directed: R6 single-clock almost-full frozen with wclk stopped
    load_ofs(4'd4, 4'd4);
    @(negedge clk);
    fwft_mode = 1'b0; async_cfg = 1'b0; retx_en = 1'b0; mark_ptr = '0;
    set_ptrs(5'd12, 5'd0);
    settle(10);
    check("R6 paf low", paf_n, 1'b0);
    @(negedge clk); wen = 1'b0;
    set_ptrs(5'd12, 5'd4);
    settle(10);
    check("R6 paf frozen without wclk", paf_n, 1'b0);
    @(negedge clk); wen = 1'b1;
    settle(10);
    check("R6 paf updates on wclk", paf_n, 1'b1);

    // R7 two-clock almost-full released by rclk alone
    @(negedge clk); async_cfg = 1'b1;
    set_ptrs(5'd12, 5'd0);
    settle(10);
    check("R7 paf low", paf_n, 1'b0);
    @(negedge clk); wen = 1'b0;
    set_ptrs(5'd12, 5'd4);
    settle(10);
    check("R7 paf released by rclk", paf_n, 1'b1);
    @(negedge clk); wen = 1'b1;
    settle(10);

    // R7 two-clock almost-empty released by wclk alone
    set_ptrs(5'd4, 5'd0);
    settle(10);
    check("R7 pae low", pae_n, 1'b0);
    @(negedge clk); ren = 1'b0;
    set_ptrs(5'd8, 5'd0);
    settle(10);
    check("R7 pae released by wclk", pae_n, 1'b1);
    @(negedge clk); ren = 1'b1;
    settle(10);

    // R6 single-clock almost-empty frozen with rclk stopped
    @(negedge clk); async_cfg = 1'b0;
    set_ptrs(5'd4, 5'd0);
    settle(10);
    check("R6 pae low", pae_n, 1'b0);
    @(negedge clk); ren = 1'b0;
    set_ptrs(5'd8, 5'd0);
    settle(10);
    check("R6 pae frozen without rclk", pae_n, 1'b0);
    @(negedge clk); ren = 1'b1;
    settle(10);
    check("R6 pae updates on rclk", pae_n, 1'b1);

    finish_run();
  end
endmodule